// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a 32-bit physical address by reading a two-level page table from memory. A request carries the page-table base register value and the virtual address. The walker then reads the first-level entry over a simple word-read memory port. It checks that entry. If the entry is valid, it forms the second-level entry address and reads that entry as well.

The virtual address is split into a 10-bit first-level index (bits 31:22), a 10-bit second-level index (bits 21:12) and a 12-bit page offset (bits 11:0). Each table entry is 32 bits wide. Bit 31 is the valid flag and bits 19:0 are the physical page number. Bit 30 marks a modified page and bits 29:20 carry nothing; the walker ignores all of bits 30:20.

A walk that meets an invalid entry stops at once and reports a fault with an all-ones result. Only one translation is in flight at a time. The requester sees a one-cycle completion pulse that carries the result and the fault flag.

Top module: `pt_walker`

## Requirements
- R1: After an active-high synchronous reset the walker is idle: `req_ready` is 1 and `done`, `mem_req`, `fault` and `result` are 0.
- R2: The first memory read goes to address {req_base[31:12], vaddr[31:22], 2'b00}, so the low 12 bits of the base are ignored.
- R3: If bit 31 of the first-level entry is 0, the walk completes with `fault`=1 and `result`=32'hFFFFFFFF, and no second read is issued.
- R4: The second memory read goes to address {L1 entry[19:0], vaddr[21:12], 2'b00}.
- R5: If bit 31 of the second-level entry is 0, the walk completes with `fault`=1 and `result`=32'hFFFFFFFF after exactly two reads.
- R6: On success, `result` = {L2 entry[19:0], vaddr[11:0]} and `fault`=0.
- R7: Entry bits 30:20 (modified flag and unused bits) do not affect the read addresses, the result or the fault flag.
- R8: `req_ready` is high only while idle. A request is accepted on a cycle with `req_valid` and `req_ready` both high. `done` is high for exactly one cycle per accepted request.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_req` stays high and `mem_addr` stays stable. Any number of wait cycles is tolerated.
- R10: Reads are strictly sequential. After an acknowledged read, `mem_req` is low for at least one cycle while the entry is checked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_base | input | 32 | Page-table base register value |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Physical address, or all ones on a fault |
| fault | output | 1 | Walk hit an invalid entry |

## Verification
The assertions watch the handshake rules on every cycle. They check that the read address holds through wait states, that a check cycle follows each acknowledged read, that `done` lasts a single cycle, that the walker accepts no request while busy, and that every fault carries the all-ones result. The address arithmetic, the choice of bits that form each entry address and the final physical address can only be confirmed by the bench's scenarios. These run against a memory model with a range of wait counts, index extremes, an unaligned base and entries with the ignored bits set. The same applies to the missing second read after a first-level fault.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

   parameter int unsigned PTW_ADDR_W = 32;
   parameter int unsigned PTW_OFF_W  = 12;
   parameter int unsigned PTW_IDX_W  = 10;
   parameter int unsigned PTW_PTE_W  = 32;

   typedef enum logic [2:0] {
      WS_IDLE    = 3'd0,
      WS_RD_TOP  = 3'd1,
      WS_CHK_TOP = 3'd2,
      WS_RD_LEAF = 3'd3,
      WS_CHK_LEAF= 3'd4,
      WS_FINISH  = 3'd5
   } walk_state_e;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFF_W  = 12,
   parameter int unsigned IDX_W  = 10,
   parameter int unsigned PTE_W  = 32
) (
   input  logic [ADDR_W-OFF_W-1:0] table_pn,
   input  logic [IDX_W-1:0]        index,
   output logic [ADDR_W-1:0]       entry_addr
);
   localparam int unsigned PN_W  = ADDR_W - OFF_W;
   localparam int unsigned SHIFT = $clog2(PTE_W / 8);

   if (PN_W + IDX_W + SHIFT != ADDR_W) begin : g_bad_split
      $error("pt_entry_addr: index plus entry size must fill one page");
   end

   // Table sits on a page boundary; index scaled by entry size fills the offset.
   assign entry_addr = {table_pn, index, {SHIFT{1'b0}}};

endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode #(
   parameter int unsigned PTE_W     = 32,
   parameter int unsigned PPN_W     = 20,
   parameter int unsigned VALID_POS = 31
) (
   input  logic [PTE_W-1:0] entry,
   output logic             present,
   output logic [PPN_W-1:0] page_num
);
   if (VALID_POS >= PTE_W || PPN_W > VALID_POS) begin : g_bad_layout
      $error("pt_entry_decode: valid flag must sit above the page number");
   end

   assign present  = entry[VALID_POS];
   assign page_num = entry[PPN_W-1:0];

   // Flag bits between the page number and the valid bit are not used.
   if (VALID_POS > PPN_W) begin : g_sink
      logic unused_flags;
      assign unused_flags = ^entry[VALID_POS-1:PPN_W];
   end
   if (PTE_W > VALID_POS + 1) begin : g_sink_hi
      logic unused_top;
      assign unused_top = ^entry[PTE_W-1:VALID_POS+1];
   end

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
   import pt_walker_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        req_valid,
   input  logic        mem_ack,
   input  logic        entry_ok,
   output walk_state_e state
);
   walk_state_e state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         WS_IDLE:     if (req_valid) state_nx = WS_RD_TOP;
         WS_RD_TOP:   if (mem_ack)   state_nx = WS_CHK_TOP;
         WS_CHK_TOP:  state_nx = entry_ok ? WS_RD_LEAF : WS_FINISH;
         WS_RD_LEAF:  if (mem_ack)   state_nx = WS_CHK_LEAF;
         WS_CHK_LEAF: state_nx = WS_FINISH;
         WS_FINISH:   state_nx = WS_IDLE;
         default:     state_nx = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= WS_IDLE;
      else     state <= state_nx;
   end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walker_pkg::*;
#(
   parameter int unsigned ADDR_W    = PTW_ADDR_W,
   parameter int unsigned OFF_W     = PTW_OFF_W,
   parameter int unsigned IDX_W     = PTW_IDX_W,
   parameter int unsigned PTE_W     = PTW_PTE_W,
   parameter int unsigned VALID_POS = PTE_W - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [ADDR_W-1:0] req_vaddr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [PTE_W-1:0]  mem_rdata,
   output logic              done,
   output logic [ADDR_W-1:0] result,
   output logic              fault
);
   localparam int unsigned PN_W   = ADDR_W - OFF_W;
   localparam int unsigned LEVELS = 2;

   if (OFF_W + LEVELS * IDX_W != ADDR_W) begin : g_bad_va
      $error("pt_walker: offset and indices must cover the virtual address");
   end
   if (PTE_W != ADDR_W) begin : g_bad_pte
      $error("pt_walker: entry width must equal the address width");
   end

   walk_state_e              state;
   logic                     req_fire;
   logic [PN_W-1:0]          base_pn_q;
   logic [ADDR_W-1:0]        va_q;
   logic [PTE_W-1:0]         pte_q;
   logic                     pte_ok;
   logic [PN_W-1:0]          pte_pn;
   logic [ADDR_W-1:0]        result_q;
   logic                     fault_q;
   logic [PN_W-1:0]          lvl_pn   [LEVELS];
   logic [IDX_W-1:0]         lvl_idx  [LEVELS];
   logic [ADDR_W-1:0]        lvl_addr [LEVELS];
   logic                     unused_base;

   assign unused_base = ^req_base[OFF_W-1:0];
   assign req_ready   = (state == WS_IDLE);
   assign req_fire    = req_valid && req_ready;

   pt_walk_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .req_valid(req_valid),
      .mem_ack  (mem_ack),
      .entry_ok (pte_ok),
      .state    (state)
   );

   pt_entry_decode #(
      .PTE_W    (PTE_W),
      .PPN_W    (PN_W),
      .VALID_POS(VALID_POS)
   ) u_decode (
      .entry   (pte_q),
      .present (pte_ok),
      .page_num(pte_pn)
   );

   // Level 0 table comes from the base register, level 1 from the stored entry.
   assign lvl_pn[0] = base_pn_q;
   assign lvl_pn[1] = pte_pn;

   for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
      assign lvl_idx[lv] = va_q[ADDR_W-1-lv*IDX_W -: IDX_W];
      pt_entry_addr #(
         .ADDR_W(ADDR_W),
         .OFF_W (OFF_W),
         .IDX_W (IDX_W),
         .PTE_W (PTE_W)
      ) u_addr (
         .table_pn  (lvl_pn[lv]),
         .index     (lvl_idx[lv]),
         .entry_addr(lvl_addr[lv])
      );
   end

   assign mem_req  = (state == WS_RD_TOP) || (state == WS_RD_LEAF);
   assign mem_addr = (state == WS_RD_LEAF) ? lvl_addr[1] : lvl_addr[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         base_pn_q <= '0;
         va_q      <= '0;
         pte_q     <= '0;
         result_q  <= '0;
         fault_q   <= 1'b0;
      end else begin
         if (req_fire) begin
            base_pn_q <= req_base[ADDR_W-1:OFF_W];
            va_q      <= req_vaddr;
         end
         if (mem_req && mem_ack) pte_q <= mem_rdata;
         if (state == WS_CHK_TOP && !pte_ok) begin
            result_q <= '1;
            fault_q  <= 1'b1;
         end
         if (state == WS_CHK_LEAF) begin
            result_q <= pte_ok ? {pte_pn, va_q[OFF_W-1:0]} : '1;
            fault_q  <= !pte_ok;
         end
      end
   end

   assign done   = (state == WS_FINISH);
   assign result = result_q;
   assign fault  = fault_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              req_ready,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack,
   input logic              done,
   input logic [ADDR_W-1:0] result,
   input logic              fault
);
   // R9
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R10
   check_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (mem_req && mem_ack) |=> !mem_req);

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R8
   ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (!mem_req && !done));

   // R3
   fault_ones_chk: assert property (@(posedge clk) disable iff (rst)
      (done && fault) |-> (result == '1));

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk      (clk),
   .rst      (rst),
   .req_ready(req_ready),
   .mem_req  (mem_req),
   .mem_addr (mem_addr),
   .mem_ack  (mem_ack),
   .done     (done),
   .result   (result),
   .fault    (fault)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_base = '0;
   logic [31:0] req_vaddr = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done;
   logic [31:0] result;
   logic        fault;

   int checks = 0;
   int errors = 0;
   int wait_n = 0;
   int wait_cnt = 0;
   int rd_cnt = 0;
   int cycles = 0;

   logic [31:0] memory [logic [31:0]];
   logic [31:0] exp_res_q [$];
   logic        exp_flt_q [$];
   int          exp_rd_q  [$];
   string       exp_tag_q [$];
   logic [31:0] exp_addr_q[$];
   string       addr_tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pt_walker i_pt_walker (
      .clk      (clk),
      .rst      (rst),
      .req_valid(req_valid),
      .req_ready(req_ready),
      .req_base (req_base),
      .req_vaddr(req_vaddr),
      .mem_req  (mem_req),
      .mem_addr (mem_addr),
      .mem_ack  (mem_ack),
      .mem_rdata(mem_rdata),
      .done     (done),
      .result   (result),
      .fault    (fault)
   );

   function automatic logic [31:0] peek(logic [31:0] a);
      return memory.exists(a) ? memory[a] : 32'h0;
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Memory model: answers after wait_n cycles, checks each read address.
   always @(negedge clk) begin
      if (rst) begin
         mem_ack  <= 1'b0;
         wait_cnt <= 0;
      end else if (mem_ack) begin
         mem_ack  <= 1'b0;
         wait_cnt <= 0;
      end else if (mem_req) begin
         if (wait_cnt >= wait_n) begin
            mem_ack   <= 1'b1;
            mem_rdata <= peek(mem_addr);
            rd_cnt    <= rd_cnt + 1;
            if (exp_addr_q.size() == 0) begin
               check("R10", "unexpected read address", mem_addr, 32'hx);
            end else begin
               check(addr_tag_q.pop_front(), "read address", mem_addr, exp_addr_q.pop_front());
            end
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end
   end

   // Monitor: compare each completion against the scoreboard.
   logic done_d = 1'b0;
   always @(negedge clk) begin
      if (!rst) begin
         if (done) begin
            if (exp_res_q.size() == 0) begin
               check("R8", "unexpected done", 32'h1, 32'h0);
            end else begin
               automatic string t = exp_tag_q.pop_front();
               check(t, "result", result, exp_res_q.pop_front());
               check(t, "fault", {31'h0, fault}, {31'h0, exp_flt_q.pop_front()});
               check(t, "read count", rd_cnt, exp_rd_q.pop_front());
               check("R8", "ready low at done", {31'h0, req_ready}, 32'h0);
               check("R8", "done single cycle", {31'h0, done_d}, 32'h0);
            end
            rd_cnt = 0;
         end
         done_d <= done;
      end
   end

   task automatic walk(logic [31:0] base, logic [31:0] va, int waits, string tag);
      logic [31:0] a1, e1, a2, e2;
      a1 = {base[31:12], va[31:22], 2'b00};
      e1 = peek(a1);
      exp_addr_q.push_back(a1);
      addr_tag_q.push_back({tag, "/R2"});
      exp_tag_q.push_back(tag);
      if (!e1[31]) begin
         exp_res_q.push_back(32'hFFFF_FFFF);
         exp_flt_q.push_back(1'b1);
         exp_rd_q.push_back(1);
      end else begin
         a2 = {e1[19:0], va[21:12], 2'b00};
         e2 = peek(a2);
         exp_addr_q.push_back(a2);
         addr_tag_q.push_back({tag, "/R4"});
         exp_res_q.push_back(e2[31] ? {e2[19:0], va[11:0]} : 32'hFFFF_FFFF);
         exp_flt_q.push_back(!e2[31]);
         exp_rd_q.push_back(2);
      end
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      wait_n    = waits;
      req_base  = base;
      req_vaddr = va;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      // Table contents
      memory[32'h0001_0004] = 32'h8000_0020;
      memory[32'h0002_000C] = 32'h8001_2345;
      memory[32'h0002_0010] = 32'h7FFF_FFFF;
      memory[32'h0001_000C] = 32'hFFF0_0030;
      memory[32'h0003_0FFC] = 32'hC55A_BCDE;
      memory[32'h0001_0FFC] = 32'h8000_0040;
      memory[32'h0004_0000] = 32'h800F_FFFF;
      memory[32'h0001_0014] = 32'h7FF0_0020;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R1", "ready after reset", {31'h0, req_ready}, 32'h1);
      check("R1", "done after reset", {31'h0, done}, 32'h0);
      check("R1", "mem_req after reset", {31'h0, mem_req}, 32'h0);
      check("R1", "fault after reset", {31'h0, fault}, 32'h0);
      check("R1", "result after reset", result, 32'h0);

      walk(32'h0001_0000, 32'h0040_3ABC, 0, "R6");
      walk(32'h0001_0000, 32'h0040_3ABC, 5, "R9");
      walk(32'h0001_0000, 32'h0080_0123, 2, "R3");
      walk(32'h0001_0000, 32'h0040_4FFF, 1, "R5");
      walk(32'h0001_0000, 32'h00FF_F456, 3, "R7");
      walk(32'h0001_0FFF, 32'h0040_3001, 0, "R2");
      walk(32'h0001_0000, 32'hFFC0_0000, 7, "R4");
      walk(32'h0001_0000, 32'h0140_3777, 0, "R7");
      walk(32'h0001_0000, 32'h0040_3ABC, 20, "R9");
      walk(32'h0005_0000, 32'h1234_5678, 0, "R3");

      while (exp_res_q.size() != 0 && cycles < WATCHDOG) @(negedge clk);
      repeat (5) @(negedge clk);
      check("R8", "ready after last walk", {31'h0, req_ready}, 32'h1);
      check("R10", "all reads consumed", exp_addr_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == WATCHDOG) begin
         checks++;
         errors++;
         $display("FAIL R8 watchdog: actual %0d cycles expected completion", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule